// File: doc/BRIEF.md
# Four-Level Nested Interrupt Priority Controller

This block decides which of six interrupt sources the processor core should service next. Each source has a request line and its own enable bit, and a global enable gates every source. Each source also has two priority bits, one taken from a high-bit priority register and one from a low-bit priority register. Together they give the source one of four levels.

The controller records which levels are currently being serviced. A pending request is offered to the core only if its level is strictly above every level in service. This allows routines to nest up to four deep. When the core accepts the offered vector it pulses an acknowledge, and the level of that source is marked as in service. When a routine ends, the core pulses a return strobe. That strobe releases the highest in-service level, so any routine that was preempted carries on and still blocks requests at or below its own level.

The request and index outputs depend combinationally on the current inputs and on the in-service state. The in-service state is the only storage in the block.

Top module: `irq_nest_ctrl`

## Requirements
- R1: After reset no level is in service, so an enabled request at the lowest level is offered straight away.
- R2: A source's level is {prio_hi[i], prio_lo[i]}. Level 3 is the highest and level 0 the lowest. When several eligible sources are pending, the one with the highest level is offered.
- R3: A source takes part in arbitration only while irq_req[i], src_en[i] and glob_en are all 1. If glob_en is 0, vec_req stays 0.
- R4: Among eligible pending sources that share the highest level, the lowest source index wins.
- R5: An acknowledge while vec_req is 1 marks the offered source's level as in service. From the next cycle on, requests at that level or below are withheld.
- R6: While a level is in service, a pending request at a strictly higher level is offered (preemption).
- R7: A return pulse releases only the highest level in service. Lower preempted levels stay in service and keep blocking requests at or below them until their own return.
- R8: An acknowledge while vec_req is 0 changes no state.
- R9: vec_req and vec_idx follow the inputs in the same cycle. vec_idx is 0 whenever vec_req is 0.
- R10: If acknowledge and return arrive in the same cycle, the highest level in service is released first, and then the offered level is marked.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| irq_req | input | NUM_SRC | Request line per source |
| glob_en | input | 1 | Global interrupt enable |
| src_en | input | NUM_SRC | Per-source enable |
| prio_lo | input | NUM_SRC | Low bit of each source's level |
| prio_hi | input | NUM_SRC | High bit of each source's level |
| vec_ack | input | 1 | Core has taken the offered vector |
| reti | input | 1 | Return-from-interrupt pulse |
| vec_req | output | 1 | A source is offered to the core |
| vec_idx | output | IDX_W | Index of the offered source |

## Verification
The offered request and index are due in the same cycle as the inputs that produce them. The bench therefore drives each vector on the falling edge and compares the outputs 1 ns later, before the next rising edge. An acknowledge or return takes effect at the next rising edge. Its result is checked through the outputs of the following vector, for example a withheld or newly allowed request. Reset is likewise judged by what the outputs offer in the first cycle after release.

// File: rtl/irq_nest_pkg.sv
package irq_nest_pkg;
   localparam int LVL_W   = 2;
   localparam int NUM_LVL = 1 << LVL_W;

   typedef logic [LVL_W-1:0]   lvl_t;
   typedef logic [NUM_LVL-1:0] svc_vec_t;

   // highest set bit of an in-service vector (0 when empty)
   function automatic lvl_t top_level(input svc_vec_t v);
      lvl_t r;
      r = '0;
      for (int l = 0; l < NUM_LVL; l++)
         if (v[l]) r = lvl_t'(l);
      return r;
   endfunction
endpackage

// File: rtl/irq_level_decode.sv
module irq_level_decode
   import irq_nest_pkg::*;
#(
   parameter int NUM_SRC = 6
) (
   input  logic [NUM_SRC-1:0]            irq_req,
   input  logic                          glob_en,
   input  logic [NUM_SRC-1:0]            src_en,
   input  logic [NUM_SRC-1:0]            prio_lo,
   input  logic [NUM_SRC-1:0]            prio_hi,
   output logic [NUM_SRC-1:0]            live,
   output logic [NUM_SRC-1:0][LVL_W-1:0] lvl
);
   for (genvar i = 0; i < NUM_SRC; i++) begin : g_src
      assign live[i] = irq_req[i] & src_en[i] & glob_en;
      assign lvl[i]  = {prio_hi[i], prio_lo[i]};
   end
endmodule

// File: rtl/irq_svc_stack.sv
module irq_svc_stack
   import irq_nest_pkg::*;
(
   input  logic     clk,
   input  logic     rst_n,
   input  logic     set_en,
   input  lvl_t     set_lvl,
   input  logic     pop,
   output svc_vec_t in_svc,
   output logic     svc_any,
   output lvl_t     svc_top
);
   svc_vec_t nxt;

   assign svc_any = |in_svc;
   assign svc_top = top_level(in_svc);

   always_comb begin
      nxt = in_svc;
      if (pop && svc_any) nxt[svc_top] = 1'b0;
      if (set_en)         nxt[set_lvl] = 1'b1;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) in_svc <= '0;
      else        in_svc <= nxt;
   end

   p_set_marks_r5: assert property (@(posedge clk) disable iff (!rst_n)
      set_en |=> in_svc[$past(set_lvl)]);

   p_pop_one_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (pop && !set_en && svc_any) |=> ($countones(in_svc) == $countones($past(in_svc)) - 1));

   p_pop_keeps_lower_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (pop && !set_en && svc_any) |=> ((in_svc | ~$past(in_svc)) != '0));

   p_idle_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (!set_en && !pop) |=> $stable(in_svc));
endmodule

// File: rtl/irq_arbiter.sv
module irq_arbiter
   import irq_nest_pkg::*;
#(
   parameter int NUM_SRC = 6,
   parameter int IDX_W   = 3
) (
   input  logic [NUM_SRC-1:0]            live,
   input  logic [NUM_SRC-1:0][LVL_W-1:0] lvl,
   input  logic                          svc_any,
   input  lvl_t                          svc_top,
   output logic                          win_valid,
   output logic [IDX_W-1:0]              win_idx,
   output lvl_t                          win_lvl
);
   logic [NUM_SRC-1:0] elig;

   for (genvar i = 0; i < NUM_SRC; i++) begin : g_elig
      assign elig[i] = live[i] & (!svc_any || (lvl[i] > svc_top));
   end

   // ascending scan with strict compare: lowest index keeps a tie
   always_comb begin
      win_valid = 1'b0;
      win_idx   = '0;
      win_lvl   = '0;
      for (int i = 0; i < NUM_SRC; i++) begin
         if (elig[i] && (!win_valid || (lvl[i] > win_lvl))) begin
            win_valid = 1'b1;
            win_idx   = IDX_W'(i);
            win_lvl   = lvl[i];
         end
      end
   end
endmodule

// File: rtl/irq_nest_ctrl.sv
module irq_nest_ctrl
   import irq_nest_pkg::*;
#(
   parameter int NUM_SRC = 6,
   localparam int IDX_W  = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [NUM_SRC-1:0] irq_req,
   input  logic               glob_en,
   input  logic [NUM_SRC-1:0] src_en,
   input  logic [NUM_SRC-1:0] prio_lo,
   input  logic [NUM_SRC-1:0] prio_hi,
   input  logic               vec_ack,
   input  logic               reti,
   output logic               vec_req,
   output logic [IDX_W-1:0]   vec_idx
);
   if (NUM_SRC < 2 || NUM_SRC > 64) begin : g_bad_src
      $error("irq_nest_ctrl: NUM_SRC must lie in 2..64");
   end

   logic [NUM_SRC-1:0]            live;
   logic [NUM_SRC-1:0][LVL_W-1:0] lvl;
   svc_vec_t                      in_svc;
   logic                          svc_any;
   lvl_t                          svc_top;
   logic                          win_valid;
   logic [IDX_W-1:0]              win_idx;
   lvl_t                          win_lvl;

   irq_level_decode #(.NUM_SRC(NUM_SRC)) u_dec (
      .irq_req(irq_req), .glob_en(glob_en), .src_en(src_en),
      .prio_lo(prio_lo), .prio_hi(prio_hi), .live(live), .lvl(lvl));

   irq_arbiter #(.NUM_SRC(NUM_SRC), .IDX_W(IDX_W)) u_arb (
      .live(live), .lvl(lvl), .svc_any(svc_any), .svc_top(svc_top),
      .win_valid(win_valid), .win_idx(win_idx), .win_lvl(win_lvl));

   irq_svc_stack u_svc (
      .clk(clk), .rst_n(rst_n),
      .set_en(vec_ack && win_valid), .set_lvl(win_lvl), .pop(reti),
      .in_svc(in_svc), .svc_any(svc_any), .svc_top(svc_top));

   assign vec_req = win_valid;
   assign vec_idx = win_idx;

   p_global_off_r3: assert property (@(posedge clk) disable iff (!rst_n)
      !glob_en |-> !vec_req);

   p_offer_live_r3: assert property (@(posedge clk) disable iff (!rst_n)
      vec_req |-> (irq_req[vec_idx] && src_en[vec_idx]));

   p_above_service_r6: assert property (@(posedge clk) disable iff (!rst_n)
      vec_req |-> (!svc_any || win_lvl > svc_top));

   p_idx_range_r4: assert property (@(posedge clk) disable iff (!rst_n)
      vec_req |-> (int'(vec_idx) < NUM_SRC));

   p_idle_idx_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !vec_req |-> (vec_idx == '0));
endmodule

// File: tb/irq_nest_ctrl_tb.sv
module irq_nest_ctrl_tb;
   localparam int N = 6;
   // levels: src0=0 src1=1 src2=2 src3=3 src4=0 src5=0
   localparam logic [N-1:0] LO = 6'b001010;
   localparam logic [N-1:0] HI = 6'b001100;

   typedef struct packed {
      logic [N-1:0] req;
      logic         gen;
      logic [N-1:0] en;
      logic         ack;
      logic         ret;
      logic         xreq;
      logic [2:0]   xidx;
      logic [3:0]   rq;
   } vec_t;

   localparam int NV = 24;
   localparam vec_t TBL [NV] = '{
      '{6'b000000, 1'b1, 6'h3F, 1'b0, 1'b0, 1'b0, 3'd0, 4'd9 },  // R9 idle
      '{6'b010001, 1'b1, 6'h3F, 1'b0, 1'b0, 1'b1, 3'd0, 4'd4 },  // R4 tie lvl0
      '{6'b010010, 1'b1, 6'h3F, 1'b0, 1'b0, 1'b1, 3'd1, 4'd2 },  // R2 lvl1 over lvl0
      '{6'b010010, 1'b0, 6'h3F, 1'b0, 1'b0, 1'b0, 3'd0, 4'd3 },  // R3 global off
      '{6'b010010, 1'b1, 6'h3D, 1'b0, 1'b0, 1'b1, 3'd4, 4'd3 },  // R3 src1 disabled
      '{6'b110000, 1'b1, 6'h3F, 1'b1, 1'b0, 1'b1, 3'd4, 4'd5 },  // R5 take lvl0
      '{6'b110000, 1'b1, 6'h3F, 1'b0, 1'b0, 1'b0, 3'd0, 4'd5 },  // R5 lvl0 withheld
      '{6'b110010, 1'b1, 6'h3F, 1'b1, 1'b0, 1'b1, 3'd1, 4'd6 },  // R6 lvl1 preempts
      '{6'b110110, 1'b1, 6'h3F, 1'b0, 1'b0, 1'b1, 3'd2, 4'd6 },  // R6 lvl2 above
      '{6'b110010, 1'b1, 6'h3F, 1'b0, 1'b0, 1'b0, 3'd0, 4'd5 },  // R5 lvl1 withheld
      '{6'b110010, 1'b1, 6'h3F, 1'b0, 1'b1, 1'b0, 3'd0, 4'd7 },  // R7 return lvl1
      '{6'b110010, 1'b1, 6'h3F, 1'b0, 1'b0, 1'b1, 3'd1, 4'd7 },  // R7 lvl1 again
      '{6'b110000, 1'b1, 6'h3F, 1'b0, 1'b0, 1'b0, 3'd0, 4'd7 },  // R7 lvl0 still held
      '{6'b110000, 1'b1, 6'h3F, 1'b0, 1'b1, 1'b0, 3'd0, 4'd7 },  // R7 return lvl0
      '{6'b110000, 1'b1, 6'h3F, 1'b0, 1'b0, 1'b1, 3'd4, 4'd7 },  // R7 lvl0 free
      '{6'b000010, 1'b1, 6'h3F, 1'b1, 1'b0, 1'b1, 3'd1, 4'd10},  // R10 take lvl1
      '{6'b000100, 1'b1, 6'h3F, 1'b1, 1'b1, 1'b1, 3'd2, 4'd10},  // R10 ack+return
      '{6'b000010, 1'b1, 6'h3F, 1'b0, 1'b0, 1'b0, 3'd0, 4'd10},  // R10 lvl2 held
      '{6'b000010, 1'b1, 6'h3F, 1'b0, 1'b1, 1'b0, 3'd0, 4'd10},  // R10 return lvl2
      '{6'b000010, 1'b1, 6'h3F, 1'b0, 1'b0, 1'b1, 3'd1, 4'd10},  // R10 lvl1 was freed
      '{6'b001000, 1'b1, 6'h3F, 1'b0, 1'b0, 1'b1, 3'd3, 4'd2 },  // R2 level 3
      '{6'b000000, 1'b1, 6'h3F, 1'b1, 1'b0, 1'b0, 3'd0, 4'd8 },  // R8 stray ack
      '{6'b010000, 1'b1, 6'h3F, 1'b0, 1'b0, 1'b1, 3'd4, 4'd8 },  // R8 nothing marked
      '{6'b100001, 1'b1, 6'h1F, 1'b0, 1'b0, 1'b1, 3'd0, 4'd4 }   // R4 src0 first
   };

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic [N-1:0] irq_req = '0, src_en = '0;
   logic         glob_en = 1'b0, vec_ack = 1'b0, reti = 1'b0;
   logic         vec_req;
   logic [2:0]   vec_idx;
   int           n_chk = 0, n_err = 0;
   logic         done = 1'b0;

   always #2.5 clk = ~clk;

   irq_nest_ctrl #(.NUM_SRC(N)) u_dut (
      .clk(clk), .rst_n(rst_n), .irq_req(irq_req), .glob_en(glob_en),
      .src_en(src_en), .prio_lo(LO), .prio_hi(HI), .vec_ack(vec_ack),
      .reti(reti), .vec_req(vec_req), .vec_idx(vec_idx));

   task automatic check(input logic xr, input logic [2:0] xi, input int rq);
      n_chk++;
      if (vec_req !== xr || vec_idx !== xi) begin
         n_err++;
         $display("FAIL R%0d: req/idx got %b/%0d expected %b/%0d", rq, vec_req, vec_idx, xr, xi);
      end
   endtask

   task automatic apply(input vec_t v);
      @(negedge clk);
      irq_req = v.req; glob_en = v.gen; src_en = v.en;
      vec_ack = v.ack; reti = v.ret;
      #1 check(v.xreq, v.xidx, int'(v.rq));
   endtask

   initial begin
      #(200000 * 5);
      if (!done) begin
         n_err++;
         $display("FAIL watchdog expired");
         $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_err);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      for (int k = 0; k < NV; k++) apply(TBL[k]);

      // R1: mark levels 0 and 3 in service, then reset clears them
      apply('{6'b010000, 1'b1, 6'h3F, 1'b1, 1'b0, 1'b1, 3'd4, 4'd1});
      apply('{6'b001000, 1'b1, 6'h3F, 1'b1, 1'b0, 1'b1, 3'd3, 4'd1});
      apply('{6'b010000, 1'b1, 6'h3F, 1'b0, 1'b0, 1'b0, 3'd0, 4'd1});
      @(negedge clk);
      vec_ack = 1'b0;
      rst_n = 1'b0;
      @(negedge clk);
      rst_n = 1'b1;
      apply('{6'b010000, 1'b1, 6'h3F, 1'b0, 1'b0, 1'b1, 3'd4, 4'd1}); // R1 lvl0 free after reset
      apply('{6'b000000, 1'b1, 6'h3F, 1'b0, 1'b0, 1'b0, 3'd0, 4'd9}); // R9 idle index

      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_err);
      $finish;
   end
endmodule